// File: doc/BRIEF.md
# Framed Parallel-to-Serial Transmitter

This block turns one byte into a ten-bit serial frame on a single output line, one bit for each rising edge of an externally supplied transmit clock. A frame opens with a start bit at logic 1, carries the eight data bits with the least significant bit first, and closes with a stop bit at logic 0. The polarity is the reverse of the usual asynchronous convention, so the line rests low between frames, which is the same level as the stop bit.

A client presents a byte on `tx_data` and raises `send`. A rising edge that sees `send` high while `busy` is low takes the byte into the shift register and starts the frame. `busy` then stays high until the stop bit has been on the line for its full bit period. A `send` that arrives during a frame is dropped. The data input is read only on the edge that starts the frame, so the client may change it at any later time.

Top module: `frame_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `ser_out` is 0 and `busy` is 0.
- R2: Whenever `busy` is 0, `ser_out` is 0.
- R3: A rising edge that samples `send`=1 while `busy`=0 starts a frame, and `busy` reads 1 from the next cycle on.
- R4: The first bit period of a frame, which is the first cycle with `busy`=1, drives the start bit with value 1.
- R5: Bit periods 1 through 8 of a frame drive `tx_data[0]` through `tx_data[7]` in that order.
- R6: Bit period 9 drives the stop bit with value 0, and `busy` is still 1 during it.
- R7: `busy` stays 1 for exactly 10 consecutive cycles for each frame and then drops to 0. The next frame can start at the first edge where `busy` is 0, so at least one idle cycle falls between two frames.
- R8: A `send` that is high at an edge where `busy`=1 has no effect. The bits and the length of the frame in progress do not change, and no extra frame follows.
- R9: The byte is captured on the starting edge. Changes to `tx_data` during a frame do not alter the bits that are sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock, rising-edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Parallel byte to be framed |
| send | input | 1 | Request to start a frame |
| ser_out | output | 1 | Serial line; idles at 0 |
| busy | output | 1 | High while a frame is on the line; low means ready |

## Verification
The checker applies several rules on every cycle:
- the line stays low whenever the block is idle;
- the start level appears on the first busy cycle;
- the stop level appears on the last busy cycle;
- `busy` lasts exactly ten cycles, and a `send` during a frame neither shortens nor extends it.

The bench scenarios cover the rest: the actual order of the data bits, immunity to changes on `tx_data` after the capture edge, the values just after reset, and back-to-back frames, all compared against a frame model built independently in the bench.

// File: rtl/ser_pkg.sv
package ser_pkg;
  parameter int unsigned SER_DATA_W = 8;
  localparam int unsigned SER_FRAME_LEN = SER_DATA_W + 2;
  localparam logic START_LVL = 1'b1;
  localparam logic STOP_LVL  = 1'b0;

  // Frame vector arranged for LSB-first shifting: bit 0 = start, top = stop.
  function automatic logic [SER_FRAME_LEN-1:0] make_frame(input logic [SER_DATA_W-1:0] d);
    return {STOP_LVL, d, START_LVL};
  endfunction
endpackage

// File: rtl/ser_bit_counter.sv
module ser_bit_counter #(
  parameter int unsigned LEN = 10,
  localparam int unsigned CW = $clog2(LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  output logic [CW-1:0] remaining,
  output logic          active,
  output logic          last_bit
);
  localparam logic [CW-1:0] LEN_V = CW'(LEN);
  localparam logic [CW-1:0] ONE_V = CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)            remaining <= '0;
    else if (load)         remaining <= LEN_V;
    else if (remaining != '0) remaining <= remaining - ONE_V;
  end

  assign active   = (remaining != '0);
  assign last_bit = (remaining == ONE_V);
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         bit_out
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)    sr <= '0;
    else if (load) sr <= load_val;
    else           sr <= {1'b0, sr[W-1:1]};
  end

  assign bit_out = sr[0];
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import ser_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SER_DATA_W-1:0] tx_data,
  input  logic                  send,
  output logic                  ser_out,
  output logic                  busy
);
  localparam int unsigned CW = $clog2(SER_FRAME_LEN + 1);

  logic          accept_evt;
  logic          frame_done_evt;
  logic [CW-1:0] bits_left;

  assign accept_evt = send & ~busy;

  ser_bit_counter #(.LEN(SER_FRAME_LEN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_evt),
    .remaining (bits_left),
    .active    (busy),
    .last_bit  (frame_done_evt)
  );

  ser_shift_reg #(.W(SER_FRAME_LEN)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .load_val (make_frame(tx_data)),
    .bit_out  (ser_out)
  );
endmodule

// File: rtl/ser_chk.sv
module ser_chk
  import ser_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic send,
  input logic busy,
  input logic ser_out,
  input logic accept_evt,
  input logic frame_done_evt
);
  logic [7:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)          run <= '0;
    else if (accept_evt) run <= 8'd1;
    else if (busy)       run <= run + 8'd1;
    else                 run <= '0;
  end

  // R2
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out);
  // R3
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !busy) |=> busy);
  // R4
  start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ser_out);
  // R6
  stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_evt |-> (busy && !ser_out));
  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run < 8'(SER_FRAME_LEN)) |=> busy);
  // R7
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run == 8'(SER_FRAME_LEN)) |=> !busy);
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && send) |=> (run == $past(run) + 8'd1 || !busy));
endmodule

bind frame_serializer ser_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .send           (send),
  .busy           (busy),
  .ser_out        (ser_out),
  .accept_evt     (accept_evt),
  .frame_done_evt (frame_done_evt)
);

// File: tb/tb_frame_serializer.sv
`timescale 1ns/1ps
module tb_frame_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       send = 1'b0;
  logic       ser_out;
  logic       busy;
  int checks = 0;
  int errors = 0;

  frame_serializer dut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data),
    .send(send), .ser_out(ser_out), .busy(busy)
  );

  always #10 clk = ~clk;

  // Expected line level in bit period k of a frame carrying byte d.
  function automatic logic exp_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b1;
    if (k == 9) return 1'b0;
    return d[k-1];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a negedge with busy low; returns just after a negedge with busy low.
  task automatic run_frame(input logic [7:0] d, input bit noisy);
    tx_data = d;
    send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    for (int k = 0; k < 10; k++) begin
      chk(k == 0 ? "R4" : (k == 9 ? "R6" : "R5"), ser_out, exp_bit(d, k));
      chk(k == 9 ? "R6" : "R3", busy, 1'b1);
      if (noisy) begin
        tx_data = 8'($urandom);   // R9
        send = 1'($urandom);      // R8
      end
      @(negedge clk);
    end
    send = 1'b0;
    chk("R7", busy, 1'b0);
    chk("R2", ser_out, 1'b0);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", ser_out, 1'b0);
    chk("R1", busy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ser_out, 1'b0);
    chk("R1", busy, 1'b0);
    // Idle with data changing but no send: R2
    for (int i = 0; i < 4; i++) begin
      tx_data = 8'($urandom);
      @(negedge clk);
      chk("R2", ser_out, 1'b0);
      chk("R2", busy, 1'b0);
    end
    // Directed corner patterns
    run_frame(8'h00, 1'b0);
    run_frame(8'hFF, 1'b0);
    run_frame(8'h5C, 1'b1);
    run_frame(8'h11, 1'b1);
    run_frame(8'h01, 1'b1);
    run_frame(8'h80, 1'b1);
    // Random frames, back-to-back with the minimum gap (R7), with noise (R8, R9)
    for (int n = 0; n < 40; n++) begin
      run_frame(8'($urandom), 1'($urandom));
      if ((n % 5) == 4) begin
        repeat (2) @(negedge clk);
        chk("R2", ser_out, 1'b0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule